// File: doc/BRIEF.md
# Sequential Radix-4 Integer Multiplier

This block forms the full 64-bit product of two 32-bit integers over several clock cycles. It does not build a full parallel array. A narrow slice multiplies the whole multiplicand by one 8-bit group of the multiplier on each pass. Inside the slice, the 8-bit group is recoded into four radix-4 digits. Each digit looks at two multiplier bits plus the neighbouring lower bit, and picks one of 0, +M, -M, +2M or -2M. The slice sum is added into a running high word. Eight finished low bits shift out into a low word on each pass.

A single control input selects the operand mode. In two's complement mode, four passes cover the 32 multiplier bits. In unsigned mode the multiplicand is zero-extended. A fifth pass then handles the zero-extension of the multiplier, so its top bit is not taken as a sign. A one-cycle strobe starts an operation. A busy flag blocks any further strobe until the product is ready. A one-cycle done pulse marks the moment the product output takes its new value. The output then holds that value until the next product completes.

Top module: `mul_radix4_iter`

## Requirements
- R1: While reset is asserted (rst_n low), busy, done and product are all zero.
- R2: A start strobe sampled while busy is low is accepted, and busy is high in the following cycle.
- R3: With signed_mode high, the result is the exact 64-bit two's complement product of mcand and mplier, both read as signed 32-bit values.
- R4: With signed_mode low, the result is the exact 64-bit product of mcand and mplier, both read as unsigned 32-bit values.
- R5: In signed mode, done is high in the cycle after the fourth rising edge that follows the edge accepting start.
- R6: In unsigned mode, done is high in the cycle after the fifth rising edge that follows the edge accepting start, one extra pass for the zero-extension.
- R7: done is high for exactly one cycle per accepted start, and busy is low whenever done is high. A new start may be accepted in the done cycle.
- R8: A start strobe sampled while busy is high is ignored. It does not change the operands, the mode, the result, the completion time or the number of done pulses.
- R9: product changes only in a cycle where done is high, and otherwise holds the last completed result.
- R10: Corner operands give exact results in both modes: 0, 1, all ones (-1 in signed mode), 0x80000000 and 0x7FFFFFFF, in every pairing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply with the present operands and mode |
| signed_mode | input | 1 | 1: two's complement operands, 0: unsigned operands |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier, consumed 8 bits per pass |
| busy | output | 1 | A product is being formed, start is ignored |
| done | output | 1 | One-cycle pulse, product has just been updated |
| product | output | 64 | Last completed product |

## Verification
The embedded properties assume the following of the inputs: start is a clean level, sampled once per edge; operands and mode matter only in the cycle that start is accepted; reset is released away from a clock edge. The stimulus changes every input at the falling edge only. It waits for busy to fall before issuing a real request. It raises start during busy only in the deliberate intrusion cases, with altered operands and mode, so that any leak of those values shows up in the product or in the done timing. Random operands are mixed with the signed and unsigned corner pairs, and some requests are issued back to back in the done cycle.

// File: rtl/mulr4_pkg.sv
package mulr4_pkg;

  // Radix-4 digit codes, 3-bit two's complement of the digit value
  localparam logic [2:0] DIG_ZERO = 3'b000;
  localparam logic [2:0] DIG_POS1 = 3'b001;
  localparam logic [2:0] DIG_POS2 = 3'b010;
  localparam logic [2:0] DIG_NEG1 = 3'b111;
  localparam logic [2:0] DIG_NEG2 = 3'b110;

  // trio = {upper bit, lower bit, neighbour below}
  function automatic logic [2:0] booth_digit(input logic [2:0] trio);
    logic [2:0] code;
    case (trio)
      3'b001, 3'b010: code = DIG_POS1;
      3'b011:         code = DIG_POS2;
      3'b100:         code = DIG_NEG2;
      3'b101, 3'b110: code = DIG_NEG1;
      default:        code = DIG_ZERO;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/mulr4_recode.sv
module mulr4_recode #(
  parameter int GRP = 8
) (
  input  logic [GRP-1:0]           grp,
  input  logic                     prev,
  output logic [3*(GRP/2)-1:0]     digits
);
  import mulr4_pkg::*;

  localparam int DIG = GRP / 2;

  for (genvar k = 0; k < DIG; k++) begin : g_dig
    if (k == 0) begin : g_first
      assign digits[3*k +: 3] = booth_digit({grp[1], grp[0], prev});
    end else begin : g_rest
      assign digits[3*k +: 3] = booth_digit({grp[2*k+1], grp[2*k], grp[2*k-1]});
    end
  end

endmodule

// File: rtl/mulr4_slice.sv
module mulr4_slice #(
  parameter int WA  = 32,
  parameter int GRP = 8
) (
  input  logic [WA:0]              m_ext,
  input  logic [3*(GRP/2)-1:0]     digits,
  output logic [WA+GRP:0]          slice
);
  import mulr4_pkg::*;

  localparam int DIG = GRP / 2;
  localparam int SW  = WA + GRP + 1;

  logic [SW-1:0] m_sx;
  logic [SW-1:0] term [DIG];

  assign m_sx = {{(SW-WA-1){m_ext[WA]}}, m_ext};

  for (genvar k = 0; k < DIG; k++) begin : g_term
    always_comb begin
      logic [SW-1:0] base;
      case (digits[3*k +: 3])
        DIG_POS1: base = m_sx;
        DIG_POS2: base = m_sx << 1;
        DIG_NEG1: base = -m_sx;
        DIG_NEG2: base = -(m_sx << 1);
        default:  base = '0;
      endcase
      term[k] = base << (2*k);
    end
  end

  always_comb begin
    slice = '0;
    for (int k = 0; k < DIG; k++) slice = slice + term[k];
  end

endmodule

// File: rtl/mulr4_ctrl.sv
module mulr4_ctrl #(
  parameter int NSTEP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic signed_mode,
  output logic busy,
  output logic load,
  output logic step,
  output logic ext_step,
  output logic last,
  output logic done
);
  localparam int CW = $clog2(NSTEP + 1) + 1;

  logic          busy_q, sgn_q, done_q;
  logic [CW-1:0] cnt_q;

  assign load     = start & ~busy_q;
  assign step     = busy_q;
  assign ext_step = busy_q & ~sgn_q & (cnt_q == CW'(NSTEP));
  assign last     = busy_q & (sgn_q ? (cnt_q == CW'(NSTEP-1)) : (cnt_q == CW'(NSTEP)));
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sgn_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        busy_q <= 1'b1;
        sgn_q  <= signed_mode;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(sgn_q)));

endmodule

// File: rtl/mul_radix4_iter.sv
module mul_radix4_iter #(
  parameter int WA  = 32,
  parameter int WB  = 32,
  parameter int GRP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              signed_mode,
  input  logic [WA-1:0]     mcand,
  input  logic [WB-1:0]     mplier,
  output logic              busy,
  output logic              done,
  output logic [WA+WB-1:0]  product
);
  localparam int NSTEP = WB / GRP;
  localparam int DIG   = GRP / 2;
  localparam int SW    = WA + GRP + 1;
  localparam int AW    = SW + 1;
  localparam int HW    = AW - GRP;
  localparam int PW    = WA + WB;

  // Named control events
  logic load_w, step_w, ext_w, last_w;

  logic [WA:0]    m_q;
  logic [WB-1:0]  b_sh;
  logic           prev_q;
  logic [HW-1:0]  hi_q;
  logic [WB-1:0]  lo_q;
  logic [PW-1:0]  prod_q;

  logic [3*DIG-1:0] digits_w;
  logic [SW-1:0]    slice_w;
  logic [AW-1:0]    sum_w;
  logic [HW-1:0]    nxt_hi;
  logic [WB-1:0]    nxt_lo;

  mulr4_ctrl #(.NSTEP(NSTEP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .signed_mode(signed_mode),
    .busy       (busy),
    .load       (load_w),
    .step       (step_w),
    .ext_step   (ext_w),
    .last       (last_w),
    .done       (done)
  );

  mulr4_recode #(.GRP(GRP)) u_recode (
    .grp   (b_sh[GRP-1:0]),
    .prev  (prev_q),
    .digits(digits_w)
  );

  mulr4_slice #(.WA(WA), .GRP(GRP)) u_slice (
    .m_ext (m_q),
    .digits(digits_w),
    .slice (slice_w)
  );

  assign sum_w  = {{GRP{hi_q[HW-1]}}, hi_q} + {slice_w[SW-1], slice_w};
  assign nxt_hi = ext_w ? sum_w[HW-1:0] : sum_w[AW-1:GRP];
  assign nxt_lo = ext_w ? lo_q : {sum_w[GRP-1:0], lo_q[WB-1:GRP]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q    <= '0;
      b_sh   <= '0;
      prev_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
      prod_q <= '0;
    end else if (load_w) begin
      m_q    <= {signed_mode & mcand[WA-1], mcand};
      b_sh   <= mplier;
      prev_q <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (step_w) begin
      hi_q <= nxt_hi;
      lo_q <= nxt_lo;
      if (!ext_w) begin
        b_sh   <= b_sh >> GRP;
        prev_q <= b_sh[GRP-1];
      end
      if (last_w) prod_q <= {nxt_hi[WA-1:0], nxt_lo};
    end
  end

  assign product = prod_q;

  // R9
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);

  // R8
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(m_q));

endmodule

// File: tb/tb_mul_radix4_iter.sv
`timescale 1ns/1ps
module tb_mul_radix4_iter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] mcand = '0;
  logic [31:0] mplier = '0;
  logic        busy, done;
  logic [63:0] product;

  mul_radix4_iter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .mcand(mcand), .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [63:0] prod;
    int          t0;
    bit          sgn;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] last_prod = '0;
  bit          prev_done = 1'b0;
  bit          mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint sa, sb_v;
    if (s) begin
      sa   = longint'($signed(a));
      sb_v = longint'($signed(b));
      return 64'(sa * sb_v);
    end
    return {32'h0, a} * {32'h0, b};
  endfunction

  // Driver: waits for idle, issues a request, records the expectation
  task automatic run(input logic [31:0] a, input logic [31:0] b, input bit s,
                     input string tag, input bit intrude);
    item_t it;
    while (busy) @(negedge clk);
    mcand = a; mplier = b; signed_mode = s; start = 1'b1;
    it.prod = ref_mul(a, b, s); it.t0 = cyc; it.sgn = s; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    if (intrude) begin
      // R8: strobe again during busy with other operands and mode
      mcand = ~a; mplier = b ^ 32'h5A5A_0F0F; signed_mode = ~s; start = 1'b1;
      @(negedge clk);
      mcand = 32'h1234_5678; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard on every done
  always @(negedge clk) begin
    if (mon_en) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 64'd1, 64'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(product === it.prod, {it.sgn ? "R3 " : "R4 ", it.tag}, product, it.prod);
          if (it.sgn) chk(cyc - it.t0 == 5, "R5 latency", 64'(cyc - it.t0), 64'd5);
          else        chk(cyc - it.t0 == 6, "R6 latency", 64'(cyc - it.t0), 64'd6);
          chk(!busy, "R7 busy low with done", 64'(busy), 64'd0);
          chk(!prev_done, "R7 single pulse", 64'(prev_done), 64'd0);
          last_prod = product;
        end
      end else begin
        chk(product === last_prod, "R9 hold", product, last_prod);
      end
      prev_done = done;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] corner [5];

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(product == 64'd0, "R1 product", product, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;

    // R10 corner pairings, both modes
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(corner[i], corner[j], s[0], "R10 corner", 1'b0);

    // R3 R4 random operands
    for (int n = 0; n < 200; n++)
      run($urandom, $urandom, n[0], "random", 1'b0);

    // R8 intrusion during busy, both modes
    for (int n = 0; n < 10; n++)
      run($urandom, $urandom, n[0], "R8 intrude", 1'b1);
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R8 intrude corner", 1'b1);

    // R9 hold after completion
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(product === last_prod, "R9 idle hold", product, last_prod);

    repeat (8) @(negedge clk);
    chk(sb.size() == 0, "R7 all results seen", 64'(sb.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule